// File: doc/BRIEF.md
# Eight-Port Self-Routing Shuffle Network

This block carries request messages from eight processor ports to eight memory-module ports. It is built from three stages of four two-input, two-output routing switches. Before each stage the port indices are shuffled by rotating the 3-bit index left by one. Each message carries its destination module number in its top three bits. Stage 0 steers on the most significant of those bits, stage 1 on the middle bit and stage 2 on the least significant bit. A 0 selects the upper switch output and a 1 selects the lower one. After the last stage the message sits on the memory port that its destination field names.

Every port uses a valid/ready handshake. Each switch output holds a one-entry register, so every stage adds one clock of latency. When two messages want the same switch output in the same cycle, a round-robin pointer for that output picks the winner. The losing message waits in place, and its processor sees ready held low until it wins.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and afterwards until a request has been accepted, every memory port has valid low.
- R2: A message leaves on the memory port whose index equals its destination field, which is the top three bits of the message (bits MSG_W-1 down to MSG_W-3).
- R3: The complete message, destination and payload alike, reaches the memory port bit-for-bit unchanged.
- R4: Each accepted message is delivered exactly once. None is lost and none is duplicated, under any pattern of memory back-pressure.
- R5: A message that meets no contention and no back-pressure becomes valid on its memory port right after the second rising edge that follows the edge accepting it, which is three edges in all.
- R6: While a memory port shows valid with ready low, on the next cycle it still shows valid with identical data.
- R7: A stalled memory port does not delay a message whose path shares no switch output with the stalled traffic. Such a message still meets the latency of R5.
- R8: When two requests entering the same switch want the same output in the same cycle, exactly one is taken and the other is taken one cycle later. Priority for each output starts with the upper input and alternates after every contended grant.
- R9: Toward a free memory port that holds ready high, one processor port can have a new message accepted on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 8 | Per-processor request valid |
| req_data_i | input | 8 x MSG_W | Per-processor message; destination field in the top 3 bits |
| req_ready_o | output | 8 | Per-processor accept |
| mem_valid_o | output | 8 | Per-memory-port message valid |
| mem_data_o | output | 8 x MSG_W | Per-memory-port message |
| mem_ready_i | input | 8 | Per-memory-port accept |

## Verification
For every message, the bench records the clock count at the edge that accepts it. The monitor looks at the memory ports two time units after each falling edge, when all inputs are stable, and takes the clock count again there. For uncontended traffic the difference must be exactly two, which is three edges including the accepting one, both on the direct paths and on the path that bypasses a stalled port. In the contention test the two competing acceptance counts must differ by exactly one. In the back-to-back test, consecutive acceptances must come one count apart. A stalled output is sampled on several successive cycles to confirm that its valid and data are held.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // one-bit left rotation of a port index: the shuffle between stages
  function automatic int rotl_idx(input int p, input int bits);
    int msk;
    msk = (1 << bits) - 1;
    return ((p << 1) | (p >> (bits - 1))) & msk;
  endfunction
endpackage

// File: rtl/omega_sw2.sv
module omega_sw2 #(
  parameter int MSG_W   = 35,
  parameter int BIT_POS = 34
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            in_valid_i,
  input  logic [1:0][MSG_W-1:0] in_data_i,
  output logic [1:0]            in_ready_o,
  output logic [1:0]            out_valid_o,
  output logic [1:0][MSG_W-1:0] out_data_o,
  input  logic [1:0]            out_ready_i
);
  logic [1:0]            v_q, prio_q, out_free, both, sel, load, want;
  logic [1:0][1:0]       req;
  logic [1:0][MSG_W-1:0] d_q;

  assign want[0] = in_data_i[0][BIT_POS];
  assign want[1] = in_data_i[1][BIT_POS];
  assign out_free = ~v_q | out_ready_i;

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      req[o][0] = in_valid_i[0] && (want[0] == 1'(o));
      req[o][1] = in_valid_i[1] && (want[1] == 1'(o));
      both[o]   = &req[o];
      sel[o]    = both[o] ? prio_q[o] : req[o][1];
      load[o]   = out_free[o] && (|req[o]);
    end
    for (int i = 0; i < 2; i++)
      in_ready_o[i] = out_free[want[i]] &&
                      !(both[want[i]] && (prio_q[want[i]] != 1'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= '0;
      d_q    <= '0;
      prio_q <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (load[o]) begin
          v_q[o] <= 1'b1;
          d_q[o] <= in_data_i[sel[o]];
          if (both[o]) prio_q[o] <= ~sel[o];
        end else if (out_ready_i[o]) begin
          v_q[o] <= 1'b0;
        end
      end
    end
  end

  assign out_valid_o = v_q;
  assign out_data_o  = d_q;
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int MSG_W   = 35,
  parameter int BIT_POS = 34
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS-1:0][MSG_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]          in_ready_o,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS-1:0][MSG_W-1:0] out_data_o,
  input  logic [N_PORTS-1:0]          out_ready_i
);
  localparam int N_SW = N_PORTS / 2;

  for (genvar k = 0; k < N_SW; k++) begin : g_sw
    omega_sw2 #(.MSG_W(MSG_W), .BIT_POS(BIT_POS)) u_sw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (in_valid_i[2*k+1:2*k]),
      .in_data_i  (in_data_i[2*k+1:2*k]),
      .in_ready_o (in_ready_o[2*k+1:2*k]),
      .out_valid_o(out_valid_o[2*k+1:2*k]),
      .out_data_o (out_data_o[2*k+1:2*k]),
      .out_ready_i(out_ready_i[2*k+1:2*k])
    );
  end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int PORT_BITS = 3,
  parameter int PAYLOAD_W = 32,
  localparam int N_PORTS  = 1 << PORT_BITS,
  localparam int MSG_W    = PORT_BITS + PAYLOAD_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_PORTS-1:0]            req_valid_i,
  input  logic [N_PORTS-1:0][MSG_W-1:0] req_data_i,
  output logic [N_PORTS-1:0]            req_ready_o,
  output logic [N_PORTS-1:0]            mem_valid_o,
  output logic [N_PORTS-1:0][MSG_W-1:0] mem_data_o,
  input  logic [N_PORTS-1:0]            mem_ready_i
);
  logic [N_PORTS-1:0]            st_in_v  [PORT_BITS];
  logic [N_PORTS-1:0][MSG_W-1:0] st_in_d  [PORT_BITS];
  logic [N_PORTS-1:0]            st_in_r  [PORT_BITS];
  logic [N_PORTS-1:0]            st_out_v [PORT_BITS];
  logic [N_PORTS-1:0][MSG_W-1:0] st_out_d [PORT_BITS];
  logic [N_PORTS-1:0]            st_out_r [PORT_BITS];

  for (genvar s = 0; s < PORT_BITS; s++) begin : g_stage
    // stage s steers on destination bit PORT_BITS-1-s (msb first)
    omega_stage #(
      .N_PORTS(N_PORTS), .MSG_W(MSG_W), .BIT_POS(MSG_W - 1 - s)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (st_in_v[s]),
      .in_data_i  (st_in_d[s]),
      .in_ready_o (st_in_r[s]),
      .out_valid_o(st_out_v[s]),
      .out_data_o (st_out_d[s]),
      .out_ready_i(st_out_r[s])
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_shuf
      localparam int Q = omega_pkg::rotl_idx(p, PORT_BITS);
      if (s == 0) begin : g_head
        assign st_in_v[0][Q]  = req_valid_i[p];
        assign st_in_d[0][Q]  = req_data_i[p];
        assign req_ready_o[p] = st_in_r[0][Q];
      end else begin : g_link
        assign st_in_v[s][Q]    = st_out_v[s-1][p];
        assign st_in_d[s][Q]    = st_out_d[s-1][p];
        assign st_out_r[s-1][p] = st_in_r[s][Q];
      end
    end
  end

  assign mem_valid_o           = st_out_v[PORT_BITS-1];
  assign mem_data_o            = st_out_d[PORT_BITS-1];
  assign st_out_r[PORT_BITS-1] = mem_ready_i;
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int PORT_BITS = 3,
  parameter int PAYLOAD_W = 32,
  localparam int N_PORTS  = 1 << PORT_BITS,
  localparam int MSG_W    = PORT_BITS + PAYLOAD_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_PORTS-1:0]            req_valid_i,
  input logic [N_PORTS-1:0][MSG_W-1:0] req_data_i,
  input logic [N_PORTS-1:0]            req_ready_o,
  input logic [N_PORTS-1:0]            mem_valid_o,
  input logic [N_PORTS-1:0][MSG_W-1:0] mem_data_o,
  input logic [N_PORTS-1:0]            mem_ready_i
);
  localparam int CAP = N_PORTS * PORT_BITS;
  int occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= 0;
    else occ_q <= occ_q + $countones(req_valid_i & req_ready_o)
                        - $countones(mem_valid_o & mem_ready_i);
  end

  // R4: in-flight count never negative nor above the register count
  a_r4_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q >= 0) && (occ_q <= CAP));

  // R1: nothing in flight means no memory port is valid
  a_r1_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == 0) |-> (mem_valid_o == '0));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    a_r2_dest_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_valid_o[p] |-> (int'(mem_data_o[p][MSG_W-1 -: PORT_BITS]) == p));

    a_r6_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o[p] && !mem_ready_i[p]) |=>
        (mem_valid_o[p] && $stable(mem_data_o[p])));
  end
endmodule

bind omega_net omega_net_chk #(.PORT_BITS(PORT_BITS), .PAYLOAD_W(PAYLOAD_W)) u_chk (.*);

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;
  localparam int BITS = 3;
  localparam int PW   = 32;
  localparam int N    = 1 << BITS;
  localparam int MW   = BITS + PW;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [N-1:0]         req_valid = '0;
  logic [N-1:0][MW-1:0] req_data = '0;
  logic [N-1:0]         req_ready;
  logic [N-1:0]         mem_valid;
  logic [N-1:0][MW-1:0] mem_data;
  logic [N-1:0]         mem_ready = '1;

  omega_net #(.PORT_BITS(BITS), .PAYLOAD_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_data_i(req_data), .req_ready_o(req_ready),
    .mem_valid_o(mem_valid), .mem_data_o(mem_data), .mem_ready_i(mem_ready)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, seq = 0;
  bit done = 0, rnd_on = 0;
  logic [MW-1:0] exp_q[$];
  int exp_cyc[$];
  int last_lat[N];
  int acc_cyc[N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one message from s to d, pushed to the scoreboard on acceptance
  task automatic send(input int s, input int d);
    logic [MW-1:0] msg;
    @(negedge clk);
    msg = {BITS'(d), 16'(seq), 8'(s), 8'($urandom)};
    seq++;
    req_data[s]  = msg;
    req_valid[s] = 1'b1;
    forever begin
      #1;
      if (req_ready[s]) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1;
    exp_q.push_back(msg);
    exp_cyc.push_back(cyc);
    acc_cyc[s]   = cyc;
    req_valid[s] = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      for (int p = 0; p < N; p++) begin
        if (mem_valid[p] && mem_ready[p]) begin
          int idx;
          idx = -1;
          for (int i = 0; i < exp_q.size(); i++)
            if (idx < 0 && exp_q[i] == mem_data[p]) idx = i;
          chk("R3 R4 message matches one outstanding item", idx >= 0, idx, 0);
          chk("R2 arrival port equals destination field",
              int'(mem_data[p][MW-1 -: BITS]) == p, int'(mem_data[p][MW-1 -: BITS]), p);
          if (idx >= 0) begin
            last_lat[p] = cyc - exp_cyc[idx];
            exp_q.delete(idx);
            exp_cyc.delete(idx);
          end
        end
      end
    end
  end

  always @(negedge clk) if (rnd_on) mem_ready = N'($urandom | $urandom);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int f, w1;
    logic [MW-1:0] held;
    #23;
    chk("R1 no valid in reset", mem_valid == '0, mem_valid, 0);
    rst_ni = 1'b1;
    idle(3);
    #2;
    chk("R1 no valid after reset", mem_valid == '0, mem_valid, 0);

    // R5 uncontended latency on several paths
    send(3, 6); idle(4);
    chk("R5 latency 3->6", last_lat[6] == 2, last_lat[6], 2);
    send(0, 7); idle(4);
    chk("R5 latency 0->7", last_lat[7] == 2, last_lat[7], 2);
    send(5, 0); idle(4);
    chk("R5 latency 5->0", last_lat[0] == 2, last_lat[0], 2);

    // R9 back-to-back from one source
    send(1, 5); f = acc_cyc[1];
    send(1, 5); send(1, 5); send(1, 5);
    chk("R9 four accepts in four cycles", acc_cyc[1] - f == 3, acc_cyc[1] - f, 3);
    idle(5);
    chk("R9 all delivered", exp_q.size() == 0, exp_q.size(), 0);

    // R8 contention: src 0 and src 4 share a first-stage switch, both want upper
    fork send(0, 0); send(4, 1); join
    chk("R8 loser one cycle later", acc_cyc[4] - acc_cyc[0] == 1, acc_cyc[4] - acc_cyc[0], 1);
    w1 = acc_cyc[0] < acc_cyc[4] ? 0 : 4;
    chk("R8 upper input wins first", w1 == 0, w1, 0);
    idle(5);
    fork send(0, 0); send(4, 1); join
    chk("R8 priority alternates", acc_cyc[0] - acc_cyc[4] == 1, acc_cyc[0] - acc_cyc[4], 1);
    idle(6);
    chk("R8 both pairs delivered", exp_q.size() == 0, exp_q.size(), 0);

    // R6 hold under back-pressure
    mem_ready[2] = 1'b0;
    send(6, 2);
    held = exp_q[$];
    idle(5); #2;
    chk("R6 valid held", mem_valid[2] == 1'b1, mem_valid[2], 1);
    chk("R6 data held", mem_data[2] == held, mem_data[2], held);
    idle(1); #2;
    chk("R6 data still held", mem_valid[2] && mem_data[2] == held, mem_data[2], held);
    mem_ready[2] = 1'b1;
    idle(3);
    chk("R6 released and delivered", exp_q.size() == 0, exp_q.size(), 0);

    // R7 stalled port does not disturb a disjoint path
    mem_ready[0] = 1'b0;
    send(0, 0); send(0, 0);
    send(7, 7); idle(4);
    chk("R7 disjoint path latency", last_lat[7] == 2, last_lat[7], 2);
    chk("R7 only stalled items remain", exp_q.size() == 2, exp_q.size(), 2);
    mem_ready[0] = 1'b1;
    idle(5);
    chk("R7 stalled items drain", exp_q.size() == 0, exp_q.size(), 0);

    // R4 random all-to-all traffic with random back-pressure
    rnd_on = 1;
    for (int s = 0; s < N; s++) begin
      fork
        automatic int ss = s;
        begin
          repeat (25) send(ss, int'($urandom_range(N - 1, 0)));
        end
      join_none
    end
    wait fork;
    rnd_on = 0;
    @(negedge clk);
    mem_ready = '1;
    idle(20);
    chk("R4 every message delivered once", exp_q.size() == 0, exp_q.size(), 0);
    #2;
    chk("R1 network idle at end", mem_valid == '0, mem_valid, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule